// File: doc/BRIEF.md
# Five-Word Combination Lock Checker

This block guards an unlock signal behind a fixed five-word secret. Every rising clock edge it samples one 8-bit code word together with a start marker. Words are grouped into consecutive frames of five. The start marker must be high on the first word of a frame and low on the other four. The secret values are, by position within the frame, 36, 19, 56, 101 and 73 (decimal).

The verdict is given only when a frame closes. It is given on the edge that samples the fifth word, and the block never aborts a frame early. A wrong word only marks the frame as failed; the remaining words are still consumed. Failed frames are counted, and correct frames do not clear the count. On the third failure the block enters a lockout state. A start marker in any non-first position also enters lockout, immediately. In lockout the outputs are pinned to "warning" until the active-low asynchronous reset clears everything.

The secret, the word width, the frame length, the failure limit and the handling of stray start markers are all parameters. The defaults give the behaviour described above.

Top module: `seqlock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, unlock and warning are both 0. The failure count is zero. The next word sampled is treated as the first word of a frame.
- R2: Outside lockout, unlock and warning change only on the edge that samples the fifth word of a frame, or on the edge that enters lockout. On every other edge they hold their values.
- R3: A frame whose words equal 36, 19, 56, 101, 73 in order, with the start marker 1 on the first word only, gives unlock=1 and warning=0 after its fifth word. The two outputs are never 1 together.
- R4: A frame in which any word differs from the secret value for its position gives unlock=0 and warning=1, and only after its fifth word. The frame still lasts five words, and the next word starts a new frame.
- R5: A frame whose first word has start marker 0 is a failed frame, even if its values are correct.
- R6: A start marker of 1 on word position 2 to 5 of a frame enters lockout on that same edge: unlock=0, warning=1.
- R7: The third failed frame since reset enters lockout. Correct frames in between do not reduce the failure count.
- R8: In lockout, unlock=0 and warning=1 are held for any input, including a correct frame, until reset.
- R9: Asserting reset clears lockout, the failure count and the frame position at once, without waiting for a clock edge. Both outputs go to 0.
- R10: The failed state of a frame does not carry over. A correct frame that follows a failed frame gives unlock=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one word sampled per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 8 | Code word for the current frame position |
| start_in | input | 1 | High marks the first word of a frame |
| unlock_o | output | 1 | High after a correct frame |
| warn_o | output | 1 | High after a failed frame or in lockout |

## Verification
Some properties can be checked on every clock. The checker does this for the following:
- the outputs hold their values except at frame close or on lockout entry;
- unlock and warning are never high together;
- a stray start marker locks the block on the next edge;
- lockout is sticky and pins the outputs;
- the failure count never passes the limit without lockout.

Other behaviour can only be shown by the bench's scenarios. The bench sweeps all 256 values at every frame position and checks each verdict against the secret. It shows that the failure count accumulates across correct frames, that a missing start marker fails a frame, and that an asynchronous reset releases lockout.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;
   // Default secret, packed with position 0 in the low byte.
   localparam logic [39:0] SEQLOCK_DEFAULT_KEY = {8'd73, 8'd101, 8'd56, 8'd19, 8'd36};

   typedef struct packed {
      logic unlock;
      logic warn;
   } seqlock_verdict_t;

   localparam seqlock_verdict_t VERDICT_IDLE = '{unlock: 1'b0, warn: 1'b0};
   localparam seqlock_verdict_t VERDICT_PASS = '{unlock: 1'b1, warn: 1'b0};
   localparam seqlock_verdict_t VERDICT_FAIL = '{unlock: 1'b0, warn: 1'b1};
endpackage

// File: rtl/seqlock_phase.sv
module seqlock_phase #(
   parameter int GROUP_LEN = 5,
   localparam int PW = $clog2(GROUP_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [PW-1:0] pos_o,
   output logic          last_o
);
   localparam logic [PW-1:0] LAST_POS = PW'(GROUP_LEN - 1);

   initial begin
      assert (GROUP_LEN >= 2) else $error("seqlock_phase: GROUP_LEN must be at least 2");
   end

   logic [PW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (step) begin
         if (pos_q == LAST_POS) pos_q <= '0;
         else                   pos_q <= pos_q + 1'b1;
      end
   end

   assign pos_o  = pos_q;
   assign last_o = (pos_q == LAST_POS);
endmodule

// File: rtl/seqlock_match.sv
module seqlock_match #(
   parameter int WORD_W = 8,
   parameter int GROUP_LEN = 5,
   parameter logic [WORD_W*GROUP_LEN-1:0] KEY = '0,
   parameter bit STRAY_LOCK = 1'b1,
   localparam int PW = $clog2(GROUP_LEN),
   localparam int SLOTS = 1 << PW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [PW-1:0]     pos,
   input  logic              last,
   input  logic [WORD_W-1:0] code_in,
   input  logic              start_in,
   output logic              group_bad_o,
   output logic              stray_o
);
   initial begin
      assert (WORD_W >= 1) else $error("seqlock_match: WORD_W must be positive");
   end

   // One comparator per frame position; unused slots never match.
   logic [SLOTS-1:0] hit;
   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slot
         if (gi < GROUP_LEN) begin : g_used
            assign hit[gi] = (code_in == KEY[gi*WORD_W +: WORD_W]);
         end else begin : g_pad
            assign hit[gi] = 1'b0;
         end
      end
   endgenerate

   logic first_pos;
   logic word_bad;
   assign first_pos = (pos == '0);

   generate
      if (STRAY_LOCK) begin : g_stray_locks
         assign stray_o  = start_in && !first_pos;
         assign word_bad = !hit[pos] || (first_pos && !start_in);
      end else begin : g_stray_counts
         assign stray_o  = 1'b0;
         assign word_bad = !hit[pos] || (start_in != first_pos);
      end
   endgenerate

   logic bad_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_q <= 1'b0;
      end else if (step) begin
         if (last) bad_q <= 1'b0;
         else      bad_q <= bad_q | word_bad;
      end
   end

   assign group_bad_o = bad_q | word_bad;
endmodule

// File: rtl/seqlock_verdict.sv
module seqlock_verdict #(
   parameter int MAX_FAILS = 3,
   localparam int FW = $clog2(MAX_FAILS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          last,
   input  logic          group_bad,
   input  logic          stray,
   output logic          unlock_o,
   output logic          warn_o,
   output logic          locked_o,
   output logic [FW-1:0] fails_o
);
   import seqlock_pkg::*;

   initial begin
      assert (MAX_FAILS >= 1) else $error("seqlock_verdict: MAX_FAILS must be at least 1");
   end

   localparam logic [FW-1:0] FINAL_FAIL = FW'(MAX_FAILS - 1);

   seqlock_verdict_t out_q;
   logic             locked_q;
   logic [FW-1:0]    fails_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q    <= VERDICT_IDLE;
         locked_q <= 1'b0;
         fails_q  <= '0;
      end else if (!locked_q) begin
         if (stray) begin
            out_q    <= VERDICT_FAIL;
            locked_q <= 1'b1;
         end else if (last) begin
            if (group_bad) begin
               out_q   <= VERDICT_FAIL;
               fails_q <= fails_q + 1'b1;
               if (fails_q == FINAL_FAIL) locked_q <= 1'b1;
            end else begin
               out_q <= VERDICT_PASS;
            end
         end
      end
   end

   assign unlock_o = out_q.unlock;
   assign warn_o   = out_q.warn;
   assign locked_o = locked_q;
   assign fails_o  = fails_q;
endmodule

// File: rtl/seqlock_ctrl.sv
module seqlock_ctrl #(
   parameter int WORD_W = 8,
   parameter int GROUP_LEN = 5,
   parameter int MAX_FAILS = 3,
   parameter bit STRAY_LOCK = 1'b1,
   parameter logic [WORD_W*GROUP_LEN-1:0] KEY = seqlock_pkg::SEQLOCK_DEFAULT_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] code_in,
   input  logic              start_in,
   output logic              unlock_o,
   output logic              warn_o
);
   localparam int PW = $clog2(GROUP_LEN);
   localparam int FW = $clog2(MAX_FAILS + 1);

   logic [PW-1:0] pos;
   logic          last;
   logic          group_bad;
   logic          stray;
   logic          locked;
   logic [FW-1:0] fails;
   logic          step;

   // Frame position and failed-frame tracking freeze once locked.
   assign step = !locked;

   seqlock_phase #(.GROUP_LEN(GROUP_LEN)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .pos_o  (pos),
      .last_o (last)
   );

   seqlock_match #(
      .WORD_W     (WORD_W),
      .GROUP_LEN  (GROUP_LEN),
      .KEY        (KEY),
      .STRAY_LOCK (STRAY_LOCK)
   ) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .pos         (pos),
      .last        (last),
      .code_in     (code_in),
      .start_in    (start_in),
      .group_bad_o (group_bad),
      .stray_o     (stray)
   );

   seqlock_verdict #(.MAX_FAILS(MAX_FAILS)) u_verdict (
      .clk       (clk),
      .rst_n     (rst_n),
      .last      (last),
      .group_bad (group_bad),
      .stray     (stray),
      .unlock_o  (unlock_o),
      .warn_o    (warn_o),
      .locked_o  (locked),
      .fails_o   (fails)
   );
endmodule

// File: rtl/seqlock_chk.sv
module seqlock_chk #(
   parameter int GROUP_LEN = 5,
   parameter int MAX_FAILS = 3,
   parameter bit STRAY_LOCK = 1'b1,
   localparam int PW = $clog2(GROUP_LEN),
   localparam int FW = $clog2(MAX_FAILS + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_in,
   input logic          unlock_o,
   input logic          warn_o,
   input logic [PW-1:0] pos,
   input logic          locked,
   input logic [FW-1:0] fails
);
   localparam logic [PW-1:0] LAST_POS = PW'(GROUP_LEN - 1);

   assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST_POS);

   assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && pos != LAST_POS && !(STRAY_LOCK && start_in && pos != '0))
      |=> $stable({unlock_o, warn_o}));

   assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(unlock_o && warn_o));

   assert_stray_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (STRAY_LOCK && start_in && pos != '0) |=> locked);

   assert_fail_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fails >= FW'(MAX_FAILS)) |-> locked);

   assert_sticky_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   assert_lock_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (!unlock_o && warn_o));
endmodule

bind seqlock_ctrl seqlock_chk #(
   .GROUP_LEN  (GROUP_LEN),
   .MAX_FAILS  (MAX_FAILS),
   .STRAY_LOCK (STRAY_LOCK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_in (start_in),
   .unlock_o (unlock_o),
   .warn_o   (warn_o),
   .pos      (pos),
   .locked   (locked),
   .fails    (fails)
);

// File: tb/test_seqlock_ctrl.sv
`timescale 1ns/1ps
module test_seqlock_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] code = 8'd0;
   logic       start = 1'b0;
   logic       unlock;
   logic       warn;

   always #4 clk = ~clk;   // 125 MHz

   seqlock_ctrl i_seqlock_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_in  (code),
      .start_in (start),
      .unlock_o (unlock),
      .warn_o   (warn)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // Bench model state, derived from the requirements.
   int m_pos = 0;
   int m_fails = 0;
   bit m_bad = 1'b0;
   bit m_lock = 1'b0;
   bit m_unl = 1'b0;
   bit m_warn = 1'b0;

   function automatic logic [7:0] key(input int i);
      case (i)
         0: return 8'd36;
         1: return 8'd19;
         2: return 8'd56;
         3: return 8'd101;
         default: return 8'd73;
      endcase
   endfunction

   task automatic check(input string tag);
      total++;
      if (unlock !== m_unl || warn !== m_warn) begin
         bad++;
         $display("FAIL %s: unlock,warn actual=%b%b expected=%b%b at %0t",
                  tag, unlock, warn, m_unl, m_warn, $time);
      end
   endtask

   task automatic model_reset();
      m_pos = 0; m_fails = 0; m_bad = 1'b0; m_lock = 1'b0;
      m_unl = 1'b0; m_warn = 1'b0;
   endtask

   // Drive one word from a falling edge, let the rising edge sample it,
   // check at the following falling edge.
   task automatic put(input logic [7:0] w, input bit s, input string tag);
      code = w;
      start = s;
      @(negedge clk);
      if (m_lock) begin
         m_unl = 1'b0; m_warn = 1'b1;
      end else if (s && m_pos != 0) begin
         m_lock = 1'b1; m_unl = 1'b0; m_warn = 1'b1;
      end else begin
         if (w != key(m_pos) || (m_pos == 0 && !s)) m_bad = 1'b1;
         if (m_pos == 4) begin
            if (m_bad) begin
               m_fails++;
               m_unl = 1'b0; m_warn = 1'b1;
               if (m_fails == 3) m_lock = 1'b1;
            end else begin
               m_unl = 1'b1; m_warn = 1'b0;
            end
            m_bad = 1'b0;
            m_pos = 0;
         end else begin
            m_pos++;
         end
      end
      check(tag);
   endtask

   // Reset asserted between edges: outputs must clear without a clock (R9).
   task automatic do_reset();
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1 model_reset();
      check("R9");
      @(negedge clk);
      @(negedge clk);
      code = 8'd0;
      start = 1'b0;
      rst_n = 1'b1;
      check("R1");
   endtask

   task automatic good_group(input string tag);
      for (int i = 0; i < 5; i++) put(key(i), i == 0, (i < 4) ? "R2" : tag);
   endtask

   task automatic bad_group(input string tag);
      for (int i = 0; i < 5; i++)
         put((i == 2) ? 8'd57 : key(i), i == 0, (i < 4) ? "R2" : tag);
   endtask

   initial begin
      model_reset();
      repeat (2) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // R3/R4: every value at every frame position.
      for (int p = 0; p < 5; p++) begin
         for (int v = 0; v < 256; v++) begin
            do_reset();
            for (int i = 0; i < 5; i++)
               put((i == p) ? 8'(v) : key(i), i == 0,
                   (i < 4) ? "R2" : ((8'(v) == key(p)) ? "R3" : "R4"));
         end
      end

      // R5: correct values but no start marker on the first word.
      do_reset();
      for (int i = 0; i < 5; i++) put(key(i), 1'b0, (i < 4) ? "R2" : "R5");
      good_group("R10");

      // R6: stray start marker at each later position, then R8 hold.
      for (int q = 1; q < 5; q++) begin
         do_reset();
         for (int i = 0; i <= q; i++) put(key(i), (i == 0) || (i == q), (i == q) ? "R6" : "R2");
         for (int i = q + 1; i < 5; i++) put(key(i), 1'b0, "R8");
         good_group("R8");
      end

      // R7/R10: failures accumulate across correct frames.
      do_reset();
      bad_group("R4");
      good_group("R10");
      bad_group("R4");
      good_group("R10");
      bad_group("R7");
      good_group("R8");
      put(8'd36, 1'b1, "R8");

      // R9: reset releases lockout mid-frame; a fresh frame unlocks.
      do_reset();
      good_group("R3");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R2: watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule